// File: doc/BRIEF.md
# Baud Divisor and Oversampling Tick Generator

This block turns a stream of single-cycle enable pulses, coming from an upstream clock prescaler, into the two timing strobes a serial port needs. A 16-bit divisor counter emits a sample tick once for every `divisor` enable pulses. A second counter counts those sample ticks and emits a bit tick once every SC sample ticks. SC is the programmable oversampling factor. The receiver uses the sample tick to oversample the line. The transmitter shifts one bit per bit tick. The resulting bit rate is input clock / (SC × divisor × prescaler ratio). For example, a 1.8432 MHz input with prescaler 1 and SC = 16 gives 115200 bps with divisor 1, 9600 bps with divisor 12 and 50 bps with divisor 0x900.

Configuration is written through a byte-wide write port. Two addresses hold the divisor bytes and a third holds the oversampling field. The external reset is asynchronous and active low. Inside the block it is released synchronously, two clock edges after the input deasserts.

Top module: `baud_tick_gen`

## Requirements
- R1: The divisor equals the byte at address 0 plus 256 times the byte at address 1. For a divisor D of 1 to 65535, `sample_tick` pulses once for every D accepted `presc_en` pulses.
- R2: `sample_tick` is registered. It is high for exactly the one cycle after the clock edge that accepts the enable pulse completing a count of D, and is low in every other cycle.
- R3: A divisor of 0 behaves as 65536: the first `sample_tick` follows the 65536th accepted enable.
- R4: A write to address 0 or 1 restarts the divisor count from zero at that edge. An enable pulse present in the write cycle is not counted. No `sample_tick` appears in the cycle after the write.
- R5: The oversampling field is `wr_data[3:0]` written at address 2, and `wr_data[7:4]` is ignored. Field values 4 to 15 give SC equal to the value. Field values 0 to 3 give SC = 16.
- R6: `bit_tick` is high in the same cycle as every SC-th `sample_tick` and is never high without `sample_tick`.
- R7: A write to address 2 restarts the sample-tick count from zero at that edge. The divisor count is not affected.
- R8: After reset both divisor bytes and the oversampling field are 0, so the divisor is 65536 and SC = 16. Both counters are cleared and both ticks are low.
- R9: A write to address 3 changes no setting and restarts no counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| presc_en | input | 1 | Single-cycle enable pulse from the prescaler |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 divisor low byte, 1 divisor high byte, 2 oversampling field, 3 unused |
| wr_data | input | 8 | Write data |
| sample_tick | output | 1 | Oversampling strobe, one cycle wide |
| bit_tick | output | 1 | Bit strobe, coincident with every SC-th sample tick |

## Verification
An enable pulse accepted at edge t shows up on `sample_tick` in the cycle after edge t, because there is one register on that path. `bit_tick` is combinational from `sample_tick` and the oversampling count, so it is due in that same cycle. A write takes effect at its own edge, so the first cycle of changed behaviour is the one after the write. The bench drives inputs on the falling edge. At the next falling edge it first compares both ticks against the prediction made for the stimulus of the previous cycle, and only then drives new inputs. Every cycle is therefore checked against exactly one cycle of registered latency.

// File: rtl/baud_pkg.sv
package baud_pkg;
  localparam int BYTE_W    = 8;
  localparam int DIV_BYTES = 2;
  localparam int DIV_W     = DIV_BYTES * BYTE_W;
  localparam int OSR_W     = 4;
  localparam int MIN_SC    = 4;
  localparam int ADDR_W    = 2;
  localparam int OSR_ADDR  = DIV_BYTES;
endpackage

// File: rtl/baud_cfg_regs.sv
module baud_cfg_regs
  import baud_pkg::*;
#(
  parameter int NBYTES = DIV_BYTES,
  parameter int OSW    = OSR_W,
  parameter int AW     = ADDR_W,
  parameter int SC_MIN = MIN_SC
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [AW-1:0]           wr_addr,
  input  logic [BYTE_W-1:0]       wr_data,
  output logic [NBYTES*BYTE_W-1:0] div_last,
  output logic [OSW-1:0]          sc_last,
  output logic                    div_reload,
  output logic                    os_reload
);
  localparam int DW = NBYTES * BYTE_W;

  logic [DW-1:0]  div_q, div_d;
  logic [OSW-1:0] osr_q, osr_d;
  logic           div_hit;

  always_comb begin
    div_d   = div_q;
    div_hit = 1'b0;
    for (int b = 0; b < NBYTES; b++) begin
      if (wr_en && (wr_addr == AW'(b))) begin
        div_d[b*BYTE_W +: BYTE_W] = wr_data;
        div_hit                   = 1'b1;
      end
    end
  end

  always_comb begin
    osr_d     = osr_q;
    os_reload = 1'b0;
    if (wr_en && (wr_addr == AW'(NBYTES))) begin
      osr_d     = wr_data[OSW-1:0];
      os_reload = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      osr_q <= '0;
    end else begin
      div_q <= div_d;
      osr_q <= osr_d;
    end
  end

  assign div_reload = div_hit;
  // a zero divisor wraps to all ones, giving a full 2**DW count
  assign div_last   = div_q - DW'(1);
  assign sc_last    = (osr_q < OSW'(SC_MIN)) ? '1 : (osr_q - OSW'(1));

  AST_SC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    sc_last >= OSW'(SC_MIN - 1)); // R5
  AST_DIV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !div_reload |=> $stable(div_q)); // R9
endmodule

// File: rtl/baud_div_cnt.sv
module baud_div_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         reload,
  input  logic [W-1:0] last,
  output logic         tick
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         tick_q, tick_d;

  always_comb begin
    cnt_d  = cnt_q;
    tick_d = 1'b0;
    if (reload) begin
      cnt_d = '0;
    end else if (en) begin
      if (cnt_q == last) begin
        cnt_d  = '0;
        tick_d = 1'b1;
      end else begin
        cnt_d = cnt_q + W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      tick_q <= tick_d;
    end
  end

  assign tick = tick_q;

  AST_DIV_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= last); // R1
  AST_TICK_FROM_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tick_q) |-> $past(en) && !$past(reload)); // R2
  AST_RELOAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> !tick_q && (cnt_q == '0)); // R4
endmodule

// File: rtl/baud_os_cnt.sv
module baud_os_cnt #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         samp,
  input  logic         reload,
  input  logic [W-1:0] last,
  output logic         bit_tick
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         wrap;

  assign wrap = (cnt_q == last);

  always_comb begin
    cnt_d = cnt_q;
    if (reload) begin
      cnt_d = '0;
    end else if (samp) begin
      cnt_d = wrap ? '0 : (cnt_q + W'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign bit_tick = samp && wrap;

  AST_OS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= last); // R6
  AST_OS_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> (cnt_q == '0)); // R7
  AST_BIT_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |=> !bit_tick); // R6
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import baud_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              presc_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  output logic              sample_tick,
  output logic              bit_tick
);
  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic [DIV_W-1:0] div_last;
  logic [OSR_W-1:0] sc_last;
  logic             div_reload;
  logic             os_reload;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  baud_cfg_regs #(
    .NBYTES(DIV_BYTES), .OSW(OSR_W), .AW(ADDR_W), .SC_MIN(MIN_SC)
  ) u_regs (
    .clk(clk), .rst_n(rst_int_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .div_last(div_last), .sc_last(sc_last),
    .div_reload(div_reload), .os_reload(os_reload)
  );

  baud_div_cnt #(.W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_int_n), .en(presc_en), .reload(div_reload),
    .last(div_last), .tick(sample_tick)
  );

  baud_os_cnt #(.W(OSR_W)) u_os (
    .clk(clk), .rst_n(rst_int_n), .samp(sample_tick), .reload(os_reload),
    .last(sc_last), .bit_tick(bit_tick)
  );

  AST_BIT_ALIGNED: assert property (@(posedge clk) disable iff (!rst_int_n)
    bit_tick |-> sample_tick); // R6
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_int_n |-> !sample_tick && !bit_tick); // R8
endmodule

// File: tb/baud_tick_gen_test.sv
`timescale 1ns/1ps
module baud_tick_gen_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       presc_en, wr_en;
  logic [1:0] wr_addr;
  logic [7:0] wr_data;
  logic       sample_tick, bit_tick;

  int checks = 0, errors = 0;
  int div_val, sc_val, e_en, e_samp;
  bit pd_wr, pd_en;
  logic [1:0] pd_addr;
  logic [7:0] pd_data;
  string tag;

  always #2 clk = ~clk;

  baud_tick_gen uut (
    .clk(clk), .rst_n(rst_n), .presc_en(presc_en), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data),
    .sample_tick(sample_tick), .bit_tick(bit_tick)
  );

  function automatic int sc_of(input logic [3:0] f);
    return (f < 4) ? 16 : int'(f);
  endfunction

  function automatic int deff(input int d);
    return (d == 0) ? 65536 : d;
  endfunction

  task automatic chk(input string t, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %b expected %b at %0t", t, what, act, exp, $time);
    end
  endtask

  task automatic observe();
    bit exp_s = 0, exp_b = 0;
    if (pd_wr) begin
      case (pd_addr)
        2'd0: begin div_val = (div_val & 32'hFF00) | int'(pd_data); e_en = 0; end
        2'd1: begin div_val = (div_val & 32'h00FF) | (int'(pd_data) << 8); e_en = 0; end
        2'd2: begin sc_val = sc_of(pd_data[3:0]); e_samp = 0; end
        default: ;
      endcase
    end
    if (pd_en && !(pd_wr && pd_addr < 2)) begin
      e_en++;
      if (e_en % deff(div_val) == 0) begin
        exp_s = 1;
        e_samp++;
        if (e_samp % sc_val == 0) exp_b = 1;
      end
    end
    chk(tag, "sample_tick", sample_tick, exp_s);
    chk(tag, "bit_tick", bit_tick, exp_b);
  endtask

  task automatic step(input bit wr, input logic [1:0] a, input logic [7:0] d, input bit en);
    @(negedge clk);
    observe();
    wr_en = wr; wr_addr = a; wr_data = d; presc_en = en;
    pd_wr = wr; pd_addr = a; pd_data = d; pd_en = en;
  endtask

  task automatic run(input int n, input int pct);
    for (int i = 0; i < n; i++) step(0, 2'd0, 8'd0, ($urandom % 100) < pct);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired, run hung");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h00c0ffee));
    rst_n = 1'b0; presc_en = 0; wr_en = 0; wr_addr = 0; wr_data = 0;
    tag = "R8";
    repeat (3) begin
      @(negedge clk);
      chk(tag, "sample_tick in reset", sample_tick, 1'b0);
      chk(tag, "bit_tick in reset", bit_tick, 1'b0);
    end
    rst_n = 1'b1;
    repeat (4) begin
      @(negedge clk);
      chk(tag, "sample_tick after reset", sample_tick, 1'b0);
    end
    div_val = 0; sc_val = 16; e_en = 0; e_samp = 0;
    pd_wr = 0; pd_en = 0; pd_addr = 0; pd_data = 0;

    // reset divisor of zero counts 65536 enables
    tag = "R3 R8";
    for (int i = 0; i < 65540; i++) step(0, 2'd0, 8'd0, 1);

    // divisor 12, default SC 16
    tag = "R1 R2 R6";
    step(1, 2'd0, 8'h0C, 0);
    run(420, 100);

    // divisor 0x0102, SC 4 with upper field bits set
    tag = "R1 R5";
    step(1, 2'd1, 8'h01, 0);
    step(1, 2'd0, 8'h02, 0);
    step(1, 2'd2, 8'hF4, 0);
    run(2200, 100);

    // field codes 1..3 and 15 with divisor 1
    tag = "R5 R6";
    step(1, 2'd1, 8'h00, 0);
    step(1, 2'd0, 8'h01, 1);
    for (int f = 1; f < 4; f++) begin
      step(1, 2'd2, 8'(f), 1);
      run(70, 100);
    end
    step(1, 2'd2, 8'h0F, 1);
    run(70, 100);
    step(1, 2'd2, 8'h07, 1);
    run(50, 70);

    // divisor write in mid count while enable is high
    tag = "R4";
    step(1, 2'd0, 8'h05, 0);
    run(3, 100);
    step(1, 2'd0, 8'h05, 1);
    run(12, 100);
    step(1, 2'd1, 8'h00, 1);
    run(12, 100);

    // oversampling restart mid count
    tag = "R7";
    step(1, 2'd0, 8'h02, 0);
    step(1, 2'd2, 8'h06, 1);
    run(9, 100);
    step(1, 2'd2, 8'h06, 1);
    run(40, 100);

    // unused address leaves everything alone
    tag = "R9";
    run(7, 100);
    step(1, 2'd3, 8'hFF, 1);
    run(40, 100);

    // constrained random mix
    tag = "R1 R4 R6 R7";
    for (int r = 0; r < 30; r++) begin
      for (int i = 0; i < 1500; i++) begin
        int p = $urandom % 100;
        if (p < 2) begin
          logic [1:0] a = 2'($urandom % 4);
          logic [7:0] d;
          if (a == 2'd0)      d = 8'(1 + $urandom % 6);
          else if (a == 2'd1) d = 8'h00;
          else                d = 8'($urandom);
          step(1, a, d, ($urandom % 2) == 0);
        end else begin
          step(0, 2'd0, 8'd0, ($urandom % 100) < 60);
        end
      end
    end

    @(negedge clk);
    observe();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule